// File: doc/BRIEF.md
# Boost PWM Gate Sequencer with Forced Off Interval

This block produces the gate command of an average-current-mode boost converter, one switching period at a time. A cycle-start strobe opens each period. The block then forces the gate low for a fixed number of clocks, holds an internal digital ramp at zero during that time, and releases the ramp afterwards. The gate turns on when the ramp reaches a threshold word captured at cycle start. The off interval therefore lengthens as the threshold rises, which matches the rule that the off duty tracks the input voltage.

A deglitched overcurrent input can end conduction early. Once it acts, the gate stays low until the next cycle start. A run-enable input takes the supply-undervoltage and fault conditions. While it is low the gate is held off and all cycle state is cleared. The averaging of the sensed current, the analog comparators and the driver stage sit outside this block.

Top module: `pwm_minoff_gate`

## Requirements
- R1: While reset is high, and on the first sample after it, gate_o, ilim_flag_o, blank_o and ramp_o are all zero.
- R2: A cycle_start_i accepted at a clock edge (run_en_i high) drives gate_o low at that edge and raises blank_o for exactly TOFF_CYC clocks. Gate_o stays low for the whole of that window. A new start during a cycle restarts it.
- R3: Ramp_o is zero at the start edge and while blank_o is high. From the first clock after blank_o falls, it rises by one per clock and stops at RAMP_TOP.
- R4: The threshold on ref_i is captured only at the accepted start edge. Later changes to ref_i have no effect within that cycle.
- R5: Gate_o rises at the first edge after the forced-off window at which the released ramp is at or above the captured threshold. With no overcurrent, it then stays high until the next start. Gate_o is therefore low for TOFF_CYC+1+threshold clocks of the period.
- R6: If the captured threshold exceeds RAMP_TOP, gate_o stays low for the whole cycle (zero duty).
- R7: Ilim_raw_i acts only after it has been high on DGL_CYC consecutive clock edges. A shorter pulse changes neither gate_o nor ilim_flag_o.
- R8: Once the deglitched overcurrent acts outside the forced-off window, gate_o goes low at the next edge and ilim_flag_o goes high. Both hold for the rest of the cycle, even after ilim_raw_i returns low.
- R9: Overcurrent seen during the forced-off window is ignored. The flag stays low, and if the input clears before the window ends, the cycle proceeds as normal.
- R10: The next accepted start clears ilim_flag_o, and conduction then proceeds per R5.
- R11: With run_en_i low, gate_o, ilim_flag_o, blank_o and ramp_o are zero from the next edge, and cycle_start_i is ignored. After run_en_i returns, gate_o stays low until a new start is accepted.
- R12: Every period has at least TOFF_CYC+1 clocks with gate_o low, which bounds the maximum duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en_i | input | 1 | High when the supply is above undervoltage and no fault is present |
| cycle_start_i | input | 1 | One-clock strobe that opens a switching period |
| ref_i | input | RAMP_W | Threshold word derived from the averaged current |
| ilim_raw_i | input | 1 | Undeglitched peak-current comparator output, synchronous to clk |
| gate_o | output | 1 | Gate command, active high |
| ilim_flag_o | output | 1 | Overcurrent latched for the current cycle |
| ramp_o | output | RAMP_W | Present ramp value |
| blank_o | output | 1 | High during the forced-off window |

## Verification
The assertions assume that ilim_raw_i and cycle_start_i are already synchronous to clk. They also assume that TOFF_CYC and DGL_CYC are at least one, and that RAMP_TOP fits in RAMP_W bits. The stimulus drives every input on the falling clock edge, so each input is a clean registered level at the next rising edge. It builds periods of known length from back-to-back start strobes. It places overcurrent pulses at chosen clock offsets: shorter than the deglitch window, inside the forced-off window, and after the gate has turned on. It also toggles run_en_i only between rising edges. Thresholds span zero, RAMP_TOP and a value above RAMP_TOP, which reaches the minimum-off, full-ramp and zero-duty corners.

// File: rtl/pmo_pkg.sv
package pmo_pkg;
  // next-state decision for the gate register
  typedef enum logic [1:0] {
    GD_HOLD  = 2'd0,
    GD_CLEAR = 2'd1,
    GD_SET   = 2'd2
  } gate_dec_t;
endpackage

// File: rtl/pmo_offtimer.sv
module pmo_offtimer #(
  parameter int TOFF_CYC = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  output logic blank,
  output logic live
);
  localparam int CW = (TOFF_CYC > 1) ? $clog2(TOFF_CYC) : 1;
  localparam logic [CW-1:0] LOAD_V = CW'(TOFF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          blank_q;
  logic          live_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q   <= '0;
      blank_q <= 1'b0;
      live_q  <= 1'b0;
    end else if (start) begin
      cnt_q   <= LOAD_V;
      blank_q <= 1'b1;
      live_q  <= 1'b1;
    end else if (blank_q) begin
      if (cnt_q == '0) blank_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign blank = blank_q;
  assign live  = live_q;

  // R2
  start_opens_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (start && en) |=> blank_q);

  // R11
  disable_clears_timer_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!blank_q && !live_q));
endmodule

// File: rtl/pmo_ramp.sv
module pmo_ramp #(
  parameter int RAMP_W   = 12,
  parameter int RAMP_TOP = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              hold,
  input  logic              run,
  output logic [RAMP_W-1:0] ramp
);
  localparam logic [RAMP_W-1:0] TOP_V = RAMP_W'(RAMP_TOP);

  logic [RAMP_W-1:0] ramp_q;

  always_ff @(posedge clk) begin
    if (rst || !en || hold) ramp_q <= '0;
    else if (run && (ramp_q < TOP_V)) ramp_q <= ramp_q + 1'b1;
  end

  assign ramp = ramp_q;

  // R3
  ramp_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_q <= TOP_V);

  // R3
  ramp_held_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (ramp_q == '0));

  // R3
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && run && !hold && ramp_q < TOP_V) |=> (ramp_q == $past(ramp_q) + 1'b1));
endmodule

// File: rtl/pmo_ilim_dgl.sv
module pmo_ilim_dgl #(
  parameter int DGL_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic raw,
  output logic dg
);
  logic dg_q;

  generate
    if (DGL_CYC <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst || !en) dg_q <= 1'b0;
        else            dg_q <= raw;
      end
    end else begin : g_count
      localparam int CW = $clog2(DGL_CYC + 1);
      localparam logic [CW-1:0] FULL_V = CW'(DGL_CYC);
      localparam logic [CW-1:0] ARM_V  = CW'(DGL_CYC - 1);
      logic [CW-1:0] run_q;
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          run_q <= '0;
          dg_q  <= 1'b0;
        end else begin
          if (!raw)                run_q <= '0;
          else if (run_q != FULL_V) run_q <= run_q + 1'b1;
          dg_q <= raw && (run_q >= ARM_V);
        end
      end
    end
  endgenerate

  assign dg = dg_q;

  // R7
  dgl_needs_raw_chk: assert property (@(posedge clk) disable iff (rst)
    dg_q |-> $past(raw));
endmodule

// File: rtl/pmo_gate_latch.sv
module pmo_gate_latch
  import pmo_pkg::*;
#(
  parameter int RAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic              blank,
  input  logic              live,
  input  logic [RAMP_W-1:0] ramp,
  input  logic [RAMP_W-1:0] ref_in,
  input  logic              dg,
  output logic              gate,
  output logic              flag
);
  logic [RAMP_W-1:0] ref_q;
  logic              gate_q;
  logic              flag_q;
  gate_dec_t         dec;

  // forced-off window outranks everything, then overcurrent, then the crossing
  always_comb begin
    dec = GD_HOLD;
    if (start || blank)                dec = GD_CLEAR;
    else if (dg || flag_q)             dec = GD_CLEAR;
    else if (live && (ramp >= ref_q))  dec = GD_SET;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ref_q  <= '0;
      gate_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (start) ref_q <= ref_in;
      if (start || blank)  flag_q <= 1'b0;
      else if (live && dg) flag_q <= 1'b1;
      case (dec)
        GD_CLEAR: gate_q <= 1'b0;
        GD_SET:   gate_q <= 1'b1;
        default:  gate_q <= gate_q;
      endcase
    end
  end

  assign gate = gate_q;
  assign flag = flag_q;

  // R2
  blank_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
    blank |=> !gate_q);

  // R8
  flag_blocks_gate_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> !gate_q);

  // R5
  rise_on_crossing_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(ramp >= ref_q));

  // R11
  disable_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!gate_q && !flag_q));

  // R10
  start_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start && en) |=> !flag_q);
endmodule

// File: rtl/pwm_minoff_gate.sv
module pwm_minoff_gate #(
  parameter int RAMP_W   = 12,
  parameter int RAMP_TOP = 4000,
  parameter int TOFF_CYC = 60,
  parameter int DGL_CYC  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en_i,
  input  logic              cycle_start_i,
  input  logic [RAMP_W-1:0] ref_i,
  input  logic              ilim_raw_i,
  output logic              gate_o,
  output logic              ilim_flag_o,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              blank_o
);
  logic start_acc;
  logic blank_w;
  logic live_w;
  logic dg_w;
  logic [RAMP_W-1:0] ramp_w;

  assign start_acc = cycle_start_i && run_en_i;

  pmo_offtimer #(.TOFF_CYC(TOFF_CYC)) u_timer (
    .clk(clk), .rst(rst), .en(run_en_i), .start(start_acc),
    .blank(blank_w), .live(live_w)
  );

  pmo_ramp #(.RAMP_W(RAMP_W), .RAMP_TOP(RAMP_TOP)) u_ramp (
    .clk(clk), .rst(rst), .en(run_en_i), .hold(start_acc || blank_w),
    .run(live_w), .ramp(ramp_w)
  );

  pmo_ilim_dgl #(.DGL_CYC(DGL_CYC)) u_dgl (
    .clk(clk), .rst(rst), .en(run_en_i), .raw(ilim_raw_i), .dg(dg_w)
  );

  pmo_gate_latch #(.RAMP_W(RAMP_W)) u_latch (
    .clk(clk), .rst(rst), .en(run_en_i), .start(start_acc),
    .blank(blank_w), .live(live_w), .ramp(ramp_w), .ref_in(ref_i),
    .dg(dg_w), .gate(gate_o), .flag(ilim_flag_o)
  );

  assign ramp_o  = ramp_w;
  assign blank_o = blank_w;
endmodule

// File: tb/pwm_minoff_gate_bench.sv
module pwm_minoff_gate_bench;
  localparam int CLK_P = 10;
  localparam int W     = 6;
  localparam int TOP   = 40;
  localparam int T     = 5;
  localparam int D     = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic cs = 1'b0;
  logic [W-1:0] ref_in = '0;
  logic ilim = 1'b0;
  logic gate, flag, blank;
  logic [W-1:0] ramp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwm_minoff_gate #(.RAMP_W(W), .RAMP_TOP(TOP), .TOFF_CYC(T), .DGL_CYC(D)) u_pwm_minoff_gate (
    .clk(clk), .rst(rst), .run_en_i(run_en), .cycle_start_i(cs), .ref_i(ref_in),
    .ilim_raw_i(ilim), .gate_o(gate), .ilim_flag_o(flag), .ramp_o(ramp), .blank_o(blank)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced once per rising edge
  int m_left = 0, m_live = 0, m_ref = 0, m_ramp = 0, m_gate = 0, m_flag = 0;
  int m_hi = 0, m_dg = 0;

  always @(posedge clk) begin
    if (rst || !run_en) begin
      m_left <= 0; m_live <= 0; m_ramp <= 0; m_gate <= 0; m_flag <= 0;
      m_hi <= 0; m_dg <= 0;
      if (rst) m_ref <= 0;
    end else begin
      m_hi <= ilim ? ((m_hi < D) ? m_hi + 1 : m_hi) : 0;
      m_dg <= (ilim && (m_hi >= D - 1)) ? 1 : 0;
      if (cs) begin
        m_left <= T; m_live <= 1; m_ref <= int'(ref_in);
        m_ramp <= 0; m_gate <= 0; m_flag <= 0;
      end else if (m_left > 0) begin
        m_left <= m_left - 1; m_ramp <= 0; m_gate <= 0; m_flag <= 0;
      end else begin
        if (m_live != 0 && m_ramp < TOP) m_ramp <= m_ramp + 1;
        if (m_live != 0 && m_dg != 0) m_flag <= 1;
        if (m_dg != 0 || m_flag != 0) m_gate <= 0;
        else if (m_live != 0 && m_ramp >= m_ref) m_gate <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(gate == m_gate[0], "R5 gate vs model", int'(gate), m_gate);
      chk(int'(ramp) == m_ramp, "R3 ramp vs model", int'(ramp), m_ramp);
      chk(blank == (m_left > 0), "R2 blank vs model", int'(blank), int'(m_left > 0));
      chk(flag == m_flag[0], "R8 flag vs model", int'(flag), m_flag);
    end
  end

  // one period of p clocks; ilim high at edges il_from .. il_from+il_len-1 (edge 0 = start)
  task automatic run_cycle(input int r, input int p, input int il_from, input int il_len,
                           output int low_cnt);
    low_cnt = 0;
    cs = 1'b1; ref_in = W'(r); ilim = 1'b0;
    for (int k = 0; k < p; k++) begin
      @(negedge clk);
      cs = 1'b0;
      if (k == 0) ref_in = '0;
      if (!gate) low_cnt++;
      ilim = ((k + 1) >= il_from) && ((k + 1) < il_from + il_len);
    end
    ilim = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    // R1
    chk(!gate && !flag && !blank && ramp == '0, "R1 reset state",
        int'({gate, flag, blank}) + int'(ramp), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!gate && !flag && !blank && ramp == '0, "R1 after reset",
        int'({gate, flag, blank}) + int'(ramp), 0);
    cmp_on = 1'b1;
    run_en = 1'b1;
    @(negedge clk);

    // R5 / R4: threshold 4 captured, ref_i zeroed mid-cycle
    run_cycle(4, 30, 0, 0, lows);
    chk(lows == T + 1 + 4, "R4 R5 off count thr=4", lows, T + 1 + 4);
    // R12: zero threshold gives the minimum off time
    run_cycle(0, 30, 0, 0, lows);
    chk(lows == T + 1, "R12 minimum off count", lows, T + 1);
    // R6: threshold above ceiling
    run_cycle(TOP + 5, 60, 0, 0, lows);
    chk(lows == 60, "R6 zero duty", lows, 60);
    // R3: threshold equal to ceiling is reached
    run_cycle(TOP, 60, 0, 0, lows);
    chk(lows == T + 1 + TOP, "R3 ramp reaches top", lows, T + 1 + TOP);
    // R7: pulse one clock short of the deglitch window
    run_cycle(4, 30, 15, D - 1, lows);
    chk(lows == T + 1 + 4, "R7 short pulse ignored", lows, T + 1 + 4);
    chk(!flag, "R7 flag after short pulse", int'(flag), 0);
    // R8: full-length pulse after turn-on
    run_cycle(4, 30, 15, D, lows);
    chk(lows == 30 - (15 + D - 1 - (T + 1 + 4) + 1), "R8 early turn-off", lows,
        30 - (15 + D - 1 - (T + 1 + 4) + 1));
    chk(flag && !gate, "R8 latched to cycle end", int'({flag, gate}), 2);
    // R10: next start clears the flag
    run_cycle(2, 20, 0, 0, lows);
    chk(lows == T + 1 + 2, "R10 normal after overcurrent", lows, T + 1 + 2);
    chk(!flag, "R10 flag cleared", int'(flag), 0);
    // R9: overcurrent inside the forced-off window
    run_cycle(3, 20, 1, 4, lows);
    chk(lows == T + 1 + 3, "R9 ignored in window", lows, T + 1 + 3);
    chk(!flag, "R9 flag stays low", int'(flag), 0);

    // R11: disable during conduction
    cs = 1'b1; ref_in = '0;
    @(negedge clk); cs = 1'b0;
    repeat (8) @(negedge clk);
    chk(gate, "R11 conducting before disable", int'(gate), 1);
    run_en = 1'b0;
    @(negedge clk);
    chk(!gate && !flag && ramp == '0 && !blank, "R11 cleared on disable",
        int'({gate, flag, blank}) + int'(ramp), 0);
    cs = 1'b1;
    @(negedge clk); cs = 1'b0;
    chk(!blank && !gate, "R11 start ignored while disabled", int'({blank, gate}), 0);
    run_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!gate, "R11 no gate until new start", int'(gate), 0);
    end
    run_cycle(2, 20, 0, 0, lows);
    chk(lows == T + 1 + 2, "R11 resumes after start", lows, T + 1 + 2);

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule